// File: doc/BRIEF.md
# Partial Store Read-Merge-Write Unit

This block turns a store request into writes on a simple memory port. Byte, halfword, word and doubleword stores each become one write. The unit truncates the source register to the store width and places it on the big-endian byte lanes of a 64-bit bus, with matching byte enables.

The four partial stores (word-left, word-right, doubleword-left and doubleword-right) each take two accesses. The unit reads the aligned unit that contains the addressed byte, merges the source register into it under a mask derived from the low address bits, and writes the full unit back to the same aligned address.

A small controller steps through idle, read, merge and write. While it is away from idle it raises `busy` and refuses new requests. Address translation, caching and fault handling belong to the surrounding pipeline.

Top module: `partial_store_merger`

## Requirements
- R1: While reset is applied and on the first cycle after it, `busy` is 0, `req_ready` is 1, and neither `mem_rd_req` nor `mem_wr_req` is raised.
- R2: Full stores issue exactly one write and no read. The operation codes are byte=0, halfword=1, word=2 and doubleword=3, and the unit puts the low 8, 16, 32 or 64 source bits on the bus. Byte offset k within the doubleword occupies bus bits [63-8k -: 8] and byte enable bit 7-k. The write address clears 0, 1, 2 or 3 low address bits respectively.
- R3: The partial word stores (codes 4 and 5) read and write at the request address with its low 2 bits cleared. The partial doubleword stores (codes 6 and 7) read and write at the address with its low 3 bits cleared.
- R4: Each partial store performs exactly one read, followed by exactly one write to the address that was read. The write starts only after the read data has been returned. A pending request holds its address, data and enables stable until it is answered.
- R5: Word-left (code 4), with o = addr[1:0] and s = 8·o: the new word keeps the memory bits outside (0xffffffff >> s) and ORs in the low 32 source bits shifted right by s.
- R6: Word-right (code 5), with s = 8·(o+1): the new word keeps the memory bits inside (0xffffffff >> s) and ORs in the source shifted left by 32-s, truncated to 32 bits.
- R7: Doubleword-left (code 6) follows R5 with a 64-bit all-ones mask, s = 8·addr[2:0] and the full 64-bit source.
- R8: Doubleword-right (code 7) follows R6 with a 64-bit mask and s = 8·(addr[2:0]+1). At addr[2:0]=7 the mask is zero, so the whole source register is written.
- R9: `busy` rises on the cycle after a request is accepted and stays high until the write is acknowledged. While `busy` is high, `req_ready` is 0 and requests are not taken.
- R10: Requests with `req_op[3]` set are refused. They cause no memory access, leave `busy` low and change no memory.
- R11: The write of a partial word store enables only the four byte lanes of the addressed word: 0xF0 when addr[2]=0, 0x0F when addr[2]=1. A partial doubleword store enables all eight lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_op | input | 4 | Store kind, codes 0..7; bit 3 set is refused |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Source register value |
| req_ready | output | 1 | Request is taken this cycle when high |
| busy | output | 1 | Store sequence in progress |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | ADDR_W | Aligned read address |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | DATA_W | Doubleword holding the read address, big-endian |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wr_addr | output | ADDR_W | Aligned write address |
| mem_wr_data | output | DATA_W | Write data on big-endian lanes |
| mem_wr_be | output | DATA_W/8 | Byte enables, bit 7-k for offset k |
| mem_wr_ack | input | 1 | Write accepted this cycle |

## Verification
The properties rely on two things from the memory side. First, `mem_rd_valid` and `mem_wr_ack` are raised only in reply to a pending request, and they drop once that request is withdrawn. Second, the returned doubleword belongs to the address that was read. The bench's memory responder follows both rules: it answers a pending request after a programmable wait, returns the bytes stored at the aligned address, and clears its reply on the following cycle. Requests are driven at the falling edge and sampled by the unit at the rising edge. The sweeps cover every operation code and every byte offset, at zero and two wait cycles.

// File: rtl/spm_pkg.sv
// Shared types for the partial store merger.
// Assumes: operation codes 0..7 are the only legal codes.
package spm_pkg;

    // Store kinds; the merge and lane logic decode bits of this value.
    typedef enum logic [2:0] {
        OP_BYTE   = 3'd0,
        OP_HALF   = 3'd1,
        OP_WORD   = 3'd2,
        OP_DWORD  = 3'd3,
        OP_WLEFT  = 3'd4,
        OP_WRIGHT = 3'd5,
        OP_DLEFT  = 3'd6,
        OP_DRIGHT = 3'd7
    } st_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MERGE = 2'd2,
        ST_WRITE = 2'd3
    } st_state_e;

    // True for the read-merge-write kinds.
    function automatic logic needs_read(st_op_e op);
        return (op == OP_WLEFT) || (op == OP_WRIGHT) ||
               (op == OP_DLEFT) || (op == OP_DRIGHT);
    endfunction

    // Number of low address bits cleared for the memory access.
    function automatic int unsigned align_bits(st_op_e op);
        case (op)
            OP_BYTE:                      return 0;
            OP_HALF:                      return 1;
            OP_WORD, OP_WLEFT, OP_WRIGHT: return 2;
            default:                      return 3;
        endcase
    endfunction

endpackage

// File: rtl/spm_lr_merge.sv
// Left/right merge of one aligned unit of W bits.
// Left keeps the memory outside the mask and ORs in src >> s.
// Right keeps the memory inside the mask and ORs in src << (W - s).
// Assumes: W is a power of two of at least 16; a shift of W yields zero.
module spm_lr_merge #(
    parameter int W = 32
) (
    input  logic                        is_right,
    input  logic [$clog2(W/8)-1:0]      ofs,
    input  logic [W-1:0]                mem,
    input  logic [W-1:0]                src,
    output logic [W-1:0]                out
);
    localparam int SW = $clog2(W) + 1;

    logic [SW-1:0] sh;
    logic [W-1:0]  mask;

    // Shift amount, mask and combined unit.
    always_comb begin
        if (is_right) begin
            sh = SW'((int'(ofs) + 1) * 8);
        end else begin
            sh = SW'(int'(ofs) * 8);
        end
        mask = {W{1'b1}} >> sh;
        if (is_right) begin
            out = (mem & mask) | (src << (SW'(W) - sh));
        end else begin
            out = (mem & ~mask) | (src >> sh);
        end
    end
endmodule

// File: rtl/spm_merge.sv
// Builds the merged doubleword for the four partial store kinds.
// Word kinds operate on the half selected by the high offset bit
// (offset 0..3 is the upper half, big-endian) and pass the other half through.
// Assumes: op is one of the partial kinds when the output is used.
module spm_merge
    import spm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  st_op_e                         op,
    input  logic [$clog2(DATA_W/8)-1:0]    ofs,
    input  logic [DATA_W-1:0]              mem,
    input  logic [DATA_W-1:0]              src,
    output logic [DATA_W-1:0]              merged
);
    localparam int OFS_W  = $clog2(DATA_W/8);
    localparam int HALF_W = DATA_W / 2;

    logic              lo_half;
    logic [HALF_W-1:0] mem_half;
    logic [HALF_W-1:0] half_out;
    logic [DATA_W-1:0] full_out;

    // Pick the word that holds the addressed byte.
    always_comb begin
        lo_half  = ofs[OFS_W-1];
        mem_half = lo_half ? mem[HALF_W-1:0] : mem[DATA_W-1:HALF_W];
    end

    spm_lr_merge #(.W(HALF_W)) u_word (
        .is_right (op == OP_WRIGHT),
        .ofs      (ofs[OFS_W-2:0]),
        .mem      (mem_half),
        .src      (src[HALF_W-1:0]),
        .out      (half_out)
    );

    spm_lr_merge #(.W(DATA_W)) u_dword (
        .is_right (op == OP_DRIGHT),
        .ofs      (ofs),
        .mem      (mem),
        .src      (src),
        .out      (full_out)
    );

    // Select the doubleword result or re-insert the merged word.
    always_comb begin
        if (op == OP_DLEFT || op == OP_DRIGHT) begin
            merged = full_out;
        end else if (lo_half) begin
            merged = {mem[DATA_W-1:HALF_W], half_out};
        end else begin
            merged = {half_out, mem[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/spm_format.sv
// Places the truncated source on big-endian byte lanes and builds byte enables.
// Unit sizes: byte 1, half 2, word kinds DATA_W/16, doubleword kinds DATA_W/8.
// Lane k (byte offset k) is bits [DATA_W-1-8k -: 8] and enable bit BYTES-1-k.
// Assumes: offsets inside a unit are ignored (unit aligned down).
module spm_format
    import spm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  st_op_e                         op,
    input  logic [$clog2(DATA_W/8)-1:0]    ofs,
    input  logic [DATA_W-1:0]              src,
    output logic [DATA_W-1:0]              data,
    output logic [DATA_W/8-1:0]            be
);
    localparam int BYTES  = DATA_W / 8;
    localparam int HBYTES = BYTES / 2;

    int nb;
    int start;
    int pos;
    logic [DATA_W-1:0] umask;
    logic [BYTES-1:0]  ube;

    // Unit size, lane position, truncation and shift onto the lanes.
    always_comb begin
        case (op)
            OP_BYTE:                      nb = 1;
            OP_HALF:                      nb = 2;
            OP_WORD, OP_WLEFT, OP_WRIGHT: nb = HBYTES;
            default:                      nb = BYTES;
        endcase
        start = int'(ofs) & ~(nb - 1);
        pos   = BYTES - nb - start;
        umask = {DATA_W{1'b1}} >> (DATA_W - 8 * nb);
        ube   = {BYTES{1'b1}} >> (BYTES - nb);
        data  = (src & umask) << (8 * pos);
        be    = ube << pos;
    end
endmodule

// File: rtl/spm_ctrl.sv
// Sequencer: idle -> write for full stores, idle -> read -> merge -> write
// for partial stores. Read and write steps wait for their handshakes.
// Assumes: start is only raised in ST_IDLE.
module spm_ctrl
    import spm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      start_partial,
    input  logic      rd_done,
    input  logic      wr_done,
    output st_state_e state
);
    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= start_partial ? ST_READ : ST_WRITE;
                ST_READ:  if (rd_done) state <= ST_MERGE;
                ST_MERGE: state <= ST_WRITE;
                ST_WRITE: if (wr_done) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/partial_store_merger.sv
// Top of the store merger: request capture, lane formatting, read-merge-write.
// Assumes: the memory answers each held request once; read data is the
// doubleword containing the read address, big-endian.
module partial_store_merger
    import spm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [3:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_data,
    output logic                  req_ready,
    output logic                  busy,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [DATA_W-1:0]     mem_wr_data,
    output logic [DATA_W/8-1:0]   mem_wr_be,
    input  logic                  mem_wr_ack
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFS_W = $clog2(BYTES);

    st_state_e         state;
    st_op_e            req_code;
    logic              accept;
    logic              req_partial;
    logic [ADDR_W-1:0] req_aligned;
    logic [DATA_W-1:0] fmt_data;
    logic [BYTES-1:0]  fmt_be;
    logic [DATA_W-1:0] merged;

    st_op_e            op_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BYTES-1:0]  be_q;

    // Request decode and address alignment.
    always_comb begin
        req_code    = st_op_e'(req_op[2:0]);
        req_ready   = (state == ST_IDLE);
        accept      = req_valid && req_ready && !req_op[3];
        req_partial = needs_read(req_code);
        req_aligned = req_addr & ({ADDR_W{1'b1}} << align_bits(req_code));
    end

    spm_format #(.DATA_W(DATA_W)) u_format (
        .op   (req_code),
        .ofs  (req_addr[OFS_W-1:0]),
        .src  (req_data),
        .data (fmt_data),
        .be   (fmt_be)
    );

    spm_merge #(.DATA_W(DATA_W)) u_merge (
        .op     (op_q),
        .ofs    (ofs_q),
        .mem    (rdata_q),
        .src    (src_q),
        .merged (merged)
    );

    spm_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .start_partial (req_partial),
        .rd_done       (mem_rd_req && mem_rd_valid),
        .wr_done       (mem_wr_req && mem_wr_ack),
        .state         (state)
    );

    // Capture the request, the read data and the merged result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_BYTE;
            ofs_q   <= '0;
            addr_q  <= '0;
            src_q   <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            if (accept) begin
                op_q    <= req_code;
                ofs_q   <= req_addr[OFS_W-1:0];
                addr_q  <= req_aligned;
                src_q   <= req_data;
                wdata_q <= fmt_data;
                be_q    <= fmt_be;
            end
            if (mem_rd_req && mem_rd_valid) begin
                rdata_q <= mem_rd_data;
            end
            if (state == ST_MERGE) begin
                wdata_q <= merged;
            end
        end
    end

    // Memory port and status outputs.
    always_comb begin
        busy        = (state != ST_IDLE);
        mem_rd_req  = (state == ST_READ);
        mem_rd_addr = addr_q;
        mem_wr_req  = (state == ST_WRITE);
        mem_wr_addr = addr_q;
        mem_wr_data = wdata_q;
        mem_wr_be   = be_q;
    end
endmodule

// File: rtl/spm_checker.sv
// Temporal checks on the merger's ports, attached by bind.
// Assumes: replies only answer pending requests.
module spm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [3:0]          req_op,
    input logic                req_ready,
    input logic                busy,
    input logic                mem_rd_req,
    input logic [ADDR_W-1:0]   mem_rd_addr,
    input logic                mem_rd_valid,
    input logic                mem_wr_req,
    input logic [ADDR_W-1:0]   mem_wr_addr,
    input logic [DATA_W-1:0]   mem_wr_data,
    input logic [DATA_W/8-1:0] mem_wr_be,
    input logic                mem_wr_ack
);
    localparam int HBYTES = DATA_W / 16;

    logic              acc;
    logic [2:0]        cap_op;
    logic              rd_seen;
    logic [ADDR_W-1:0] rd_addr_seen;

    assign acc = req_valid && req_ready && !req_op[3];

    // Remember the accepted kind and the completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_op       <= 3'd0;
            rd_seen      <= 1'b0;
            rd_addr_seen <= '0;
        end else if (acc) begin
            cap_op  <= req_op[2:0];
            rd_seen <= 1'b0;
        end else if (mem_rd_req && mem_rd_valid) begin
            rd_seen      <= 1'b1;
            rd_addr_seen <= mem_rd_addr;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_rd_req && !mem_wr_req));

    assert_no_read_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> cap_op[2]);

    assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (cap_op[1] ? (mem_rd_addr[2:0] == 3'd0)
                                  : (mem_rd_addr[1:0] == 2'd0)));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)
                                         && $stable(mem_wr_data) && $stable(mem_wr_be)));

    assert_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && cap_op[2]) |-> (rd_seen && (mem_wr_addr == rd_addr_seen)));

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_wr_req && mem_wr_ack)) |=> busy);

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op[3]) |=> !busy);

    assert_be_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && cap_op[2]) |-> (cap_op[1] ? (mem_wr_be == '1)
                                                 : ($countones(mem_wr_be) == HBYTES)));
endmodule

bind partial_store_merger spm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_ready    (req_ready),
    .busy         (busy),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_be    (mem_wr_be),
    .mem_wr_ack   (mem_wr_ack)
);

// File: tb/test_partial_store_merger.sv
`timescale 1ns/1ps
module test_partial_store_merger;
    localparam int AW = 16;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_op = 4'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready;
    logic          busy;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          mem_wr_req;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic [7:0]    mem_wr_be;
    logic          mem_wr_ack = 1'b0;

    partial_store_merger #(.ADDR_W(AW), .DATA_W(DW)) i_partial_store_merger (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready), .busy(busy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack)
    );

    always #4 clk = ~clk;

    logic [7:0]    mem_b [0:31];
    logic [7:0]    ref_b [0:31];
    int            lat = 0;
    int            wait_cnt = 0;
    int            rd_count = 0;
    int            wr_count = 0;
    logic [AW-1:0] rd_addr_last = '0;
    logic [AW-1:0] wr_addr_last = '0;
    logic [7:0]    wr_be_last = '0;
    int            tests = 0;
    int            fails = 0;
    bit            finished = 0;

    // Memory responder: answers held requests after lat falling edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0;
            mem_wr_ack   = 1'b0;
            wait_cnt     = 0;
        end else begin
            mem_rd_valid = 1'b0;
            mem_wr_ack   = 1'b0;
            if (mem_rd_req) begin
                if (wait_cnt >= lat) begin
                    for (int k = 0; k < 8; k++)
                        mem_rd_data[63-8*k -: 8] = mem_b[{mem_rd_addr[4:3], 3'b000} + k];
                    mem_rd_valid = 1'b1;
                    rd_addr_last = mem_rd_addr;
                    rd_count++;
                    wait_cnt = 0;
                end else wait_cnt++;
            end else if (mem_wr_req) begin
                if (wait_cnt >= lat) begin
                    for (int k = 0; k < 8; k++)
                        if (mem_wr_be[7-k])
                            mem_b[{mem_wr_addr[4:3], 3'b000} + k] = mem_wr_data[63-8*k -: 8];
                    mem_wr_ack   = 1'b1;
                    wr_addr_last = mem_wr_addr;
                    wr_be_last   = mem_wr_be;
                    wr_count++;
                    wait_cnt = 0;
                end else wait_cnt++;
            end
        end
    end

    function automatic logic [63:0] mem_dw(int idx);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[63-8*k -: 8] = mem_b[idx*8 + k];
        return v;
    endfunction

    function automatic logic [63:0] ref_dw(int idx);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[63-8*k -: 8] = ref_b[idx*8 + k];
        return v;
    endfunction

    function automatic string op_req(int op);
        case (op)
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Byte-wise reference of each store kind (big-endian).
    task automatic ref_store(input int op, input logic [AW-1:0] addr, input logic [63:0] src);
        int base = int'(addr[4:3]) * 8;
        int a = int'(addr[2:0]);
        int w = a & 4;
        int o = a & 3;
        case (op)
            0: ref_b[base+a] = src[7:0];
            1: begin ref_b[base+(a&6)] = src[15:8]; ref_b[base+(a&6)+1] = src[7:0]; end
            2: for (int i = 0; i < 4; i++) ref_b[base+w+i] = src[31-8*i -: 8];
            3: for (int i = 0; i < 8; i++) ref_b[base+i] = src[63-8*i -: 8];
            4: for (int i = 0; i < 4-o; i++) ref_b[base+w+o+i] = src[31-8*i -: 8];
            5: for (int k = 0; k <= o; k++) ref_b[base+w+k] = src[31-8*(k+3-o) -: 8];
            6: for (int i = 0; i < 8-a; i++) ref_b[base+a+i] = src[63-8*i -: 8];
            default: for (int k = 0; k <= a; k++) ref_b[base+k] = src[63-8*(k+7-a) -: 8];
        endcase
    endtask

    function automatic logic [AW-1:0] aligned(int op, logic [AW-1:0] addr);
        case (op)
            0: return addr;
            1: return addr & ~16'd1;
            2, 4, 5: return addr & ~16'd3;
            default: return addr & ~16'd7;
        endcase
    endfunction

    task automatic do_store(input int op, input logic [AW-1:0] addr, input logic [63:0] src);
        int idx = int'(addr[4:3]);
        rd_count = 0;
        wr_count = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_addr  = addr;
        req_data  = src;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        ref_store(op, addr, src);
        check(mem_dw(idx) == ref_dw(idx), op_req(op), mem_dw(idx), ref_dw(idx));
        check(wr_count == 1, "R4", 64'(wr_count), 64'd1);
        if (op >= 4) begin
            check(rd_count == 1, "R4", 64'(rd_count), 64'd1);
            check(rd_addr_last == aligned(op, addr), "R3", 64'(rd_addr_last), 64'(aligned(op, addr)));
            check(wr_addr_last == rd_addr_last, "R4", 64'(wr_addr_last), 64'(rd_addr_last));
            check(wr_be_last == ((op >= 6) ? 8'hFF : (addr[2] ? 8'h0F : 8'hF0)), "R11",
                  64'(wr_be_last), 64'((op >= 6) ? 8'hFF : (addr[2] ? 8'h0F : 8'hF0)));
        end else begin
            check(rd_count == 0, "R2", 64'(rd_count), 64'd0);
            check(wr_addr_last == aligned(op, addr), "R2", 64'(wr_addr_last), 64'(aligned(op, addr)));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_b[i] = 8'($urandom);
            ref_b[i] = mem_b[i];
        end
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        check(!busy && req_ready && !mem_rd_req && !mem_wr_req, "R1",
              {60'd0, busy, req_ready, mem_rd_req, mem_wr_req}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready && !mem_rd_req && !mem_wr_req, "R1",
              {60'd0, busy, req_ready, mem_rd_req, mem_wr_req}, 64'h4);

        // Sweep every kind and offset at two response latencies.
        for (int pat = 0; pat < 2; pat++) begin
            lat = pat * 2;
            for (int op = 0; op < 8; op++) begin
                for (int a = 0; a < 8; a++) begin
                    logic [AW-1:0] addr = AW'(((a + op) % 4) * 8 + a);
                    logic [63:0] src = {32'($urandom), 32'($urandom)};
                    do_store(op, addr, src);
                end
            end
        end

        // R8: offset 7 writes the whole register.
        do_store(7, 16'd15, 64'h0123_4567_89AB_CDEF);
        check(mem_dw(1) == 64'h0123_4567_89AB_CDEF, "R8", mem_dw(1), 64'h0123_4567_89AB_CDEF);

        // R9: busy span and refusal of a competing request.
        begin
            int busy_cycles = 0;
            int ready_seen = 0;
            lat = 3;
            rd_count = 0;
            wr_count = 0;
            @(negedge clk);
            req_valid = 1'b1; req_op = 4'd7; req_addr = 16'd15; req_data = 64'hFEDC_BA98_7654_3210;
            @(negedge clk);
            req_op = 4'd3; req_addr = 16'd16; req_data = 64'h0;
            while (busy) begin
                if (req_ready) ready_seen++;
                busy_cycles++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            ref_store(7, 16'd15, 64'hFEDC_BA98_7654_3210);
            repeat (3) @(negedge clk);
            check(busy_cycles == 9, "R9", 64'(busy_cycles), 64'd9);
            check(ready_seen == 0, "R9", 64'(ready_seen), 64'd0);
            check(wr_count == 1, "R9", 64'(wr_count), 64'd1);
            check(mem_dw(2) == ref_dw(2), "R9", mem_dw(2), ref_dw(2));
            check(mem_dw(1) == ref_dw(1), "R8", mem_dw(1), ref_dw(1));
        end

        // R10: refused operation codes.
        lat = 0;
        for (int code = 8; code < 16; code++) begin
            rd_count = 0;
            wr_count = 0;
            @(negedge clk);
            req_valid = 1'b1; req_op = 4'(code); req_addr = 16'd8; req_data = '1;
            @(negedge clk);
            req_valid = 1'b0;
            check(!busy, "R10", 64'(busy), 64'd0);
            repeat (2) @(negedge clk);
            check(rd_count == 0 && wr_count == 0, "R10", 64'(rd_count + wr_count), 64'd0);
            check(mem_dw(1) == ref_dw(1), "R10", mem_dw(1), ref_dw(1));
        end

        finish_run();
    end
endmodule